// File: doc/BRIEF.md
# Video Line Packetizer with Nibble Output

The block frames raw sensor lines for transport over a narrow parallel bus. A readout controller requests a line by giving its type, line number, trailer value and padding length. The packetizer then emits the line as a sequence of words. First comes a header: an escape pair, a line-type code and the line number coded in two bytes. Next comes the payload, which holds pixels pulled from the controller, a register dump, or filler. Last comes a footer: an escape pair, an end-of-line code and the trailer. Padding words may follow the footer. Padding only lengthens the line; the distance from header to footer does not change.

Each word leaves as two nibbles, most significant first. There are two bus formats. In wide mode each word is 10 bits and goes out on five wires. In narrow mode each word is 8 bits and goes out on four wires. A qualification clock runs next to the data in one of two styles. A frame-start strobe marks the status line, the line that carries register contents. One control input asks the pad ring to release the data, clock and strobe pins. Every nibble lasts two clock cycles, so a word takes four cycles.

Top module: `video_line_packer`

## Requirements
- R1: In wide mode a word W[9:0] is sent as W[9:5] then W[4:0] on d_o. Each nibble is held for two clock cycles.
- R2: In narrow mode the 8-bit value B goes out as {0,B[7:4]} then {0,B[3:0]}, so d_o[4] is 0. A pixel uses B = pix_i[9:2], clamped as in R6.
- R3: In wide mode every non-pixel byte B (codes, line-number bytes, trailer, register values, markers, filler) is sent as the word {B,2'b00}.
- R4: A line starts with the bytes 0xFF, 0x00, a type code and then the line number in two bytes: {2'b00,num[11:6]} followed by {2'b00,num[5:0]}. Type codes by line_type_i: 0 status→0x81, 1 active→0x82, 2 black→0x84, 3 dark→0x88, 4 blank→0x90, 5 end-of-frame→0xA0, any other value→0x90.
- R5: After AW payload words come 0xFF, 0x00, the end-of-line code 0xC0 and the trailer byte. A trailer of 0xFF is sent as 0xFE.
- R6: On active, black and dark lines each payload word is one pixel. pix_req_o pulses once per payload word, and pix_i is sampled in the same cycle. A wide pixel whose upper byte is 0xFF becomes 0x3FB. A narrow pixel byte of 0xFF becomes 0xFE.
- R7: On the status line, payload slots 0 and 1 hold filler 0x07. Slots 2..33 alternate between register r (bits regs_i[8r+7:8r], with 0xFF sent as 0xFE) and the marker 0x3C, starting at r=0. All later slots hold 0x07.
- R8: The payload of blank, end-of-frame and unknown lines is 0x07 throughout, and these lines raise no pixel requests.
- R9: pad_len_i filler words (0x07) follow the trailer. ready_o stays low from the start request until the last word of the line, padding included, has finished. The line is therefore AW+9+pad_len_i words long.
- R10: With fast_qck_i high, qck_o is high in the first cycle of each nibble and low in the second.
- R11: With fast_qck_i low, qck_o is high from the second cycle of the first nibble through the first cycle of the second nibble, and low otherwise.
- R12: fst_o is high for the first AW+8 words of a status line and low at all other times.
- R13: While hiz_i is high, out_en_o is low and d_o, qck_o and fst_o are driven to 0.
- R14: After reset ready_o is high, and fst_o and pix_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Line request, taken while ready_o is high |
| line_type_i | input | 3 | Line type of the request |
| line_num_i | input | LNUM_W | Line number of the request |
| trailer_i | input | 8 | Trailer byte (line average or frame count) |
| pad_len_i | input | PAD_W | Filler words sent after the trailer |
| wide_i | input | 1 | 1: five-wire 10-bit format, 0: four-wire 8-bit format |
| regs_i | input | NREG*8 | Register values for the status line |
| pix_i | input | 10 | Pixel, valid in the cycle pix_req_o is high |
| pix_req_o | output | 1 | Pixel consumed at this clock edge |
| ready_o | output | 1 | Idle, able to take a new line |
| fast_qck_i | input | 1 | Selects the qualification clock style |
| hiz_i | input | 1 | Asks the pad ring to release the outputs |
| out_en_o | output | 1 | Output enable to the pad ring |
| d_o | output | 5 | Nibble bus |
| qck_o | output | 1 | Qualification clock |
| fst_o | output | 1 | Frame-start strobe |

## Verification
The assertions rely on three properties of the inputs. The pixel source must present pix_i in the same cycle as pix_req_o. Requests may only be made while ready_o is high. The line parameters must stay constant from the request until the line is done. The bench meets these conditions in every test. It drives pix_i from its own counter, which advances one cycle after each request it sees. It waits for ready_o before each line. It changes fast_qck_i and hiz_i only while the block is idle.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  localparam logic [7:0] ESC_HI = 8'hFF;
  localparam logic [7:0] ESC_LO = 8'h00;
  localparam logic [7:0] EOL    = 8'hC0;
  localparam logic [7:0] FILL   = 8'h07;
  localparam logic [7:0] MARK   = 8'h3C;

  localparam logic [2:0] LT_STATUS = 3'd0;
  localparam logic [2:0] LT_ACTIVE = 3'd1;
  localparam logic [2:0] LT_BLACK  = 3'd2;
  localparam logic [2:0] LT_DARK   = 3'd3;
  localparam logic [2:0] LT_BLANK  = 3'd4;
  localparam logic [2:0] LT_EOF    = 3'd5;

  function automatic logic [7:0] line_code(logic [2:0] lt);
    case (lt)
      LT_STATUS: return 8'h81;
      LT_ACTIVE: return 8'h82;
      LT_BLACK:  return 8'h84;
      LT_DARK:   return 8'h88;
      LT_EOF:    return 8'hA0;
      default:   return 8'h90;
    endcase
  endfunction

  // keeps any data byte from forming an escape
  function automatic logic [7:0] clamp8(logic [7:0] b);
    return (b == 8'hFF) ? 8'hFE : b;
  endfunction

  // byte to bus-form word {msn,lsn}
  function automatic logic [9:0] byte_bus(logic [7:0] b, logic wide);
    return wide ? {b, 2'b00} : {1'b0, b[7:4], 1'b0, b[3:0]};
  endfunction
endpackage

// File: rtl/vlp_word_gen.sv
module vlp_word_gen
  import vlp_pkg::*;
#(
  parameter int AW     = 40,
  parameter int NREG   = 16,
  parameter int LNUM_W = 12,
  parameter int IW     = 9
) (
  input  logic [IW-1:0]     idx_i,
  input  logic [2:0]        lt_i,
  input  logic [LNUM_W-1:0] num_i,
  input  logic [7:0]        trl_i,
  input  logic              wide_i,
  input  logic [NREG*8-1:0] regs_i,
  input  logic [9:0]        pix_i,
  output logic [9:0]        word_o,
  output logic              pix_o,
  output logic              fst_o
);
  localparam int HALF = LNUM_W / 2;
  localparam int PB   = 5;            // payload base
  localparam int EB   = PB + AW;      // footer base
  localparam int RB   = 2;            // first register slot
  localparam int RE   = RB + 2 * NREG;

  int k, s, j;
  logic [7:0] b, hi_b, lo_b;
  logic [9:0] pix_bus;
  logic is_vid;

  always_comb begin
    hi_b = '0;
    lo_b = '0;
    hi_b[LNUM_W-HALF-1:0] = num_i[LNUM_W-1:HALF];
    lo_b[HALF-1:0]        = num_i[HALF-1:0];
    k = int'(idx_i);
    s = k - PB;
    j = s - RB;
    is_vid = (lt_i == LT_ACTIVE) || (lt_i == LT_BLACK) || (lt_i == LT_DARK);
    b     = FILL;
    pix_o = 1'b0;
    if (k == 0)      b = ESC_HI;
    else if (k == 1) b = ESC_LO;
    else if (k == 2) b = line_code(lt_i);
    else if (k == 3) b = hi_b;
    else if (k == 4) b = lo_b;
    else if (k < EB) begin
      if (is_vid) pix_o = 1'b1;
      else if (lt_i == LT_STATUS && s >= RB && s < RE)
        b = j[0] ? MARK : clamp8(regs_i[(j/2)*8 +: 8]);
    end
    else if (k == EB)     b = ESC_HI;
    else if (k == EB + 1) b = ESC_LO;
    else if (k == EB + 2) b = EOL;
    else if (k == EB + 3) b = clamp8(trl_i);

    if (wide_i) pix_bus = (pix_i[9:2] == 8'hFF) ? 10'h3FB : pix_i;
    else        pix_bus = byte_bus(clamp8(pix_i[9:2]), 1'b0);

    fst_o  = (lt_i == LT_STATUS) && (k < AW + 8);
    word_o = pix_o ? pix_bus : byte_bus(b, wide_i);
  end
endmodule

// File: rtl/vlp_line_seq.sv
module vlp_line_seq #(
  parameter int AW     = 40,
  parameter int LNUM_W = 12,
  parameter int PAD_W  = 8,
  parameter int IW     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [2:0]        lt_i,
  input  logic [LNUM_W-1:0] num_i,
  input  logic [7:0]        trl_i,
  input  logic [PAD_W-1:0]  pad_i,
  input  logic              wide_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              emit_o,
  output logic [IW-1:0]     sel_o,
  output logic [2:0]        lt_o,
  output logic [LNUM_W-1:0] num_o,
  output logic [7:0]        trl_o,
  output logic              wide_o
);
  logic busy_q, pend_q;
  logic [IW-1:0] idx_q, total;
  logic [PAD_W-1:0] pad_q;
  logic last;

  assign total   = IW'(AW + 9) + IW'(pad_q);
  assign last    = busy_q && (idx_q == total);
  assign emit_o  = (busy_q && !last) || (!busy_q && pend_q);
  assign sel_o   = busy_q ? idx_q : '0;
  assign ready_o = !busy_q && !pend_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
      pad_q  <= '0;
      lt_o   <= '0;
      num_o  <= '0;
      trl_o  <= '0;
      wide_o <= 1'b1;
    end else begin
      if (start_i && ready_o) begin
        pend_q <= 1'b1;
        lt_o   <= lt_i;
        num_o  <= num_i;
        trl_o  <= trl_i;
        pad_q  <= pad_i;
        wide_o <= wide_i;
      end
      if (tick_i) begin
        if (busy_q) begin
          if (last) busy_q <= 1'b0;
          else      idx_q  <= idx_q + IW'(1);
        end else if (pend_q) begin
          busy_q <= 1'b1;
          pend_q <= 1'b0;
          idx_q  <= IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vlp_nibble_tx.sv
module vlp_nibble_tx
  import vlp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       emit_i,
  input  logic [9:0] word_i,
  input  logic       fst_i,
  input  logic       wide_i,
  input  logic       fast_i,
  input  logic       hiz_i,
  output logic       tick_o,
  output logic       out_en_o,
  output logic [4:0] d_o,
  output logic       qck_o,
  output logic       fst_o
);
  logic [1:0] ph_q;
  logic [9:0] word_q;
  logic       fst_q;
  logic [4:0] d;
  logic       q;

  assign tick_o = (ph_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      word_q <= byte_bus(FILL, 1'b1);
      fst_q  <= 1'b0;
    end else begin
      ph_q <= ph_q + 2'd1;
      if (tick_o) begin
        word_q <= emit_i ? word_i : byte_bus(FILL, wide_i);
        fst_q  <= emit_i && fst_i;
      end
    end
  end

  assign d = ph_q[1] ? word_q[4:0] : word_q[9:5];
  // fast: high in first half of each nibble; slow: high across the nibble seam
  assign q = fast_i ? ~ph_q[0] : (ph_q[0] ^ ph_q[1]);

  assign out_en_o = !hiz_i;
  assign d_o      = hiz_i ? 5'd0 : d;
  assign qck_o    = !hiz_i && q;
  assign fst_o    = !hiz_i && fst_q;
endmodule

// File: rtl/video_line_packer.sv
module video_line_packer
  import vlp_pkg::*;
#(
  parameter int AW     = 40,
  parameter int NREG   = 16,
  parameter int LNUM_W = 12,
  parameter int PAD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [2:0]        line_type_i,
  input  logic [LNUM_W-1:0] line_num_i,
  input  logic [7:0]        trailer_i,
  input  logic [PAD_W-1:0]  pad_len_i,
  input  logic              wide_i,
  input  logic [NREG*8-1:0] regs_i,
  input  logic [9:0]        pix_i,
  output logic              pix_req_o,
  output logic              ready_o,
  input  logic              fast_qck_i,
  input  logic              hiz_i,
  output logic              out_en_o,
  output logic [4:0]        d_o,
  output logic              qck_o,
  output logic              fst_o
);
  localparam int IW = $clog2(AW + 9 + (1 << PAD_W));

  logic              tick, emit, busy, wide_q, pix_w, fst_w;
  logic [IW-1:0]     sel;
  logic [2:0]        lt_q;
  logic [LNUM_W-1:0] num_q;
  logic [7:0]        trl_q;
  logic [9:0]        word_w;

  vlp_line_seq #(.AW(AW), .LNUM_W(LNUM_W), .PAD_W(PAD_W), .IW(IW)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(line_start_i), .lt_i(line_type_i),
    .num_i(line_num_i), .trl_i(trailer_i), .pad_i(pad_len_i), .wide_i(wide_i),
    .busy_o(busy), .ready_o(ready_o), .emit_o(emit), .sel_o(sel), .lt_o(lt_q),
    .num_o(num_q), .trl_o(trl_q), .wide_o(wide_q)
  );

  vlp_word_gen #(.AW(AW), .NREG(NREG), .LNUM_W(LNUM_W), .IW(IW)) u_gen (
    .idx_i(sel), .lt_i(lt_q), .num_i(num_q), .trl_i(trl_q), .wide_i(wide_q),
    .regs_i(regs_i), .pix_i(pix_i), .word_o(word_w), .pix_o(pix_w), .fst_o(fst_w)
  );

  vlp_nibble_tx u_tx (
    .clk_i, .rst_ni, .emit_i(emit), .word_i(word_w), .fst_i(fst_w),
    .wide_i(wide_i), .fast_i(fast_qck_i), .hiz_i(hiz_i), .tick_o(tick),
    .out_en_o(out_en_o), .d_o(d_o), .qck_o(qck_o), .fst_o(fst_o)
  );

  assign pix_req_o = tick && emit && pix_w;
endmodule

// File: rtl/video_line_packer_chk.sv
module video_line_packer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick,
  input logic       emit,
  input logic       busy,
  input logic [9:0] word_w,
  input logic       wide_q,
  input logic       fst_w,
  input logic [2:0] lt_q,
  input logic       pix_req_o,
  input logic       qck_o,
  input logic       fast_qck_i,
  input logic       hiz_i
);
  a_r6_req_on_word_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> tick && emit);

  a_r6_pixel_never_escape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_req_o |-> ((wide_q ? word_w[9:2] : {word_w[8:5], word_w[3:0]}) != 8'hFF));

  a_r4_line_opens_with_escape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && emit && !busy) |-> (wide_q ? (word_w == 10'h3FC) : (word_w == 10'h1EF)));

  a_r12_strobe_status_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit && fst_w) |-> (lt_q == 3'd0));

  a_r10_fast_clock_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_qck_i && $past(fast_qck_i) && !hiz_i && !$past(hiz_i)) |-> (qck_o != $past(qck_o)));
endmodule

bind video_line_packer video_line_packer_chk u_chk (.*);

// File: tb/video_line_packer_bench.sv
module video_line_packer_bench;
  localparam int AW = 40;
  localparam int NREG = 16;

  logic clk = 0;
  logic rst_ni = 0;
  logic line_start = 0;
  logic [2:0] line_type = 0;
  logic [11:0] line_num = 0;
  logic [7:0] trailer = 0;
  logic [7:0] pad_len = 0;
  logic wide = 1;
  logic [NREG*8-1:0] regs = '0;
  logic [9:0] pix;
  logic fast = 0, hiz = 0;
  logic pix_req, ready, out_en, qck, fst;
  logic [4:0] d;
  int pix_n = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  function automatic logic [9:0] pf(int n);
    if (n < 4) return 10'h3FC + 10'(n);
    return 10'((n * 37 + 11) % 1024);
  endfunction
  assign pix = pf(pix_n);

  video_line_packer #(.AW(AW), .NREG(NREG), .LNUM_W(12), .PAD_W(8)) u_video_line_packer (
    .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start), .line_type_i(line_type),
    .line_num_i(line_num), .trailer_i(trailer), .pad_len_i(pad_len), .wide_i(wide),
    .regs_i(regs), .pix_i(pix), .pix_req_o(pix_req), .ready_o(ready),
    .fast_qck_i(fast), .hiz_i(hiz), .out_en_o(out_en), .d_o(d), .qck_o(qck), .fst_o(fst)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cl8(logic [7:0] b);
    return (b == 8'hFF) ? 8'hFE : b;
  endfunction
  function automatic logic [9:0] bb(logic [7:0] b, logic w);
    return w ? {b, 2'b00} : {1'b0, b[7:4], 1'b0, b[3:0]};
  endfunction
  function automatic logic [7:0] rv(int r);
    return (r == 5) ? 8'hFF : 8'((r * 29 + 1) % 256);
  endfunction
  function automatic logic [7:0] code(int lt);
    case (lt)
      0: return 8'h81; 1: return 8'h82; 2: return 8'h84;
      3: return 8'h88; 5: return 8'hA0; default: return 8'h90;
    endcase
  endfunction

  function automatic logic [9:0] exp_word(int k, int lt, logic [11:0] num, logic [7:0] trl, logic w);
    int s;
    logic [9:0] p;
    s = k - 5;
    if (k == 0) return bb(8'hFF, w);
    if (k == 1) return bb(8'h00, w);
    if (k == 2) return bb(code(lt), w);
    if (k == 3) return bb({2'b00, num[11:6]}, w);
    if (k == 4) return bb({2'b00, num[5:0]}, w);
    if (k < 5 + AW) begin
      if (lt >= 1 && lt <= 3) begin
        p = pf(s);
        if (w) return (p[9:2] == 8'hFF) ? 10'h3FB : p;
        return bb(cl8(p[9:2]), 1'b0);
      end
      if (lt == 0 && s >= 2 && s < 34)
        return ((s - 2) % 2 == 1) ? bb(8'h3C, w) : bb(cl8(rv((s - 2) / 2)), w);
      return bb(8'h07, w);
    end
    if (k == 5 + AW) return bb(8'hFF, w);
    if (k == 6 + AW) return bb(8'h00, w);
    if (k == 7 + AW) return bb(8'hC0, w);
    if (k == 8 + AW) return bb(cl8(trl), w);
    return bb(8'h07, w);
  endfunction

  function automatic string rtag(int k, int lt, logic w);
    string m;
    m = w ? "R1" : "R2";
    if (k < 5) return {"R4 ", m};
    if (k < 5 + AW) return {(lt >= 1 && lt <= 3) ? "R6 " : (lt == 0 ? "R7 " : "R8 "), m};
    if (k < 9 + AW) return {"R5 ", m};
    return {"R9 ", m};
  endfunction

  // word capture from slow qualification clock
  logic [9:0] wbuf [0:511];
  logic wfst [0:511];
  logic wrdy [0:511];
  int wn = 0;
  initial begin
    logic pq;
    logic [4:0] ms;
    pq = 0;
    ms = 0;
    forever begin
      @(negedge clk);
      if (!fast && !hiz) begin
        if (!pq && qck) ms = d;
        else if (pq && qck) begin
          if (wn < 512) begin
            wbuf[wn] = {ms, d};
            wfst[wn] = fst;
            wrdy[wn] = ready;
          end
          wn++;
        end
      end
      pq = qck;
    end
  end

  // pixel source: advance one cycle after a request
  initial begin
    logic seen;
    seen = 0;
    forever begin
      @(negedge clk);
      if (seen) pix_n++;
      seen = pix_req;
    end
  end

  task automatic do_line(int lt, logic [11:0] num, logic [7:0] trl, int pad, logic w);
    int i0, total;
    logic [9:0] esc;
    @(negedge clk);
    while (!ready) @(negedge clk);
    @(posedge clk);
    wn = 0;
    pix_n = 0;
    @(negedge clk);
    line_type = 3'(lt);
    line_num = num;
    trailer = trl;
    pad_len = 8'(pad);
    wide = w;
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    while (!ready) @(negedge clk);
    repeat (12) @(negedge clk);
    esc = bb(8'hFF, w);
    total = AW + 9 + pad;
    i0 = -1;
    for (int i = 0; i < wn && i < 512; i++)
      if (i0 < 0 && wbuf[i] == esc) i0 = i;
    chk(i0 >= 0 && i0 + total < wn, "R4 header escape found", i0, 0);
    if (i0 < 0 || i0 + total >= wn) return;
    for (int k = 0; k < total; k++) begin
      chk(wbuf[i0 + k] == exp_word(k, lt, num, trl, w), rtag(k, lt, w),
          int'(wbuf[i0 + k]), int'(exp_word(k, lt, num, trl, w)));
      chk(wfst[i0 + k] == (lt == 0 && k < AW + 8), "R12 strobe", int'(wfst[i0 + k]),
          int'(lt == 0 && k < AW + 8));
      chk(wrdy[i0 + k] == 1'b0, "R9 ready low in line", int'(wrdy[i0 + k]), 0);
    end
    chk(wrdy[i0 + total] == 1'b1, "R9 ready after padding", int'(wrdy[i0 + total]), 1);
    chk(wfst[i0 + total] == 1'b0, "R12 strobe after line", int'(wfst[i0 + total]), 0);
    if (w) begin
      chk(wbuf[i0 + 2][1:0] == 2'b00, "R3 code low bits", int'(wbuf[i0 + 2][1:0]), 0);
      chk(wbuf[i0 + AW + 8][1:0] == 2'b00, "R3 trailer low bits", int'(wbuf[i0 + AW + 8][1:0]), 0);
    end
    chk(pix_n == ((lt >= 1 && lt <= 3) ? AW : 0), (lt >= 1 && lt <= 3) ? "R6 pixel requests" : "R8 no pixel requests",
        pix_n, (lt >= 1 && lt <= 3) ? AW : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] qs [0:11];
    logic [4:0] ds [0:11];
    int r0;
    for (int r = 0; r < NREG; r++) regs[r*8 +: 8] = rv(r);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(ready == 1'b1, "R14 ready after reset", int'(ready), 1);
    chk(fst == 1'b0, "R14 strobe after reset", int'(fst), 0);
    chk(pix_req == 1'b0, "R14 no request after reset", int'(pix_req), 0);

    do_line(0, 12'h000, 8'h2A, 0, 1'b1);
    do_line(1, 12'hA5C, 8'h91, 3, 1'b1);
    do_line(2, 12'h123, 8'h44, 0, 1'b0);
    do_line(3, 12'h7C1, 8'h10, 1, 1'b1);
    do_line(4, 12'h3E8, 8'h00, 2, 1'b0);
    do_line(5, 12'h1E0, 8'hFF, 0, 1'b1);
    do_line(1, 12'hFFF, 8'hFF, 5, 1'b0);
    do_line(0, 12'h001, 8'h05, 4, 1'b0);
    do_line(7, 12'h055, 8'h33, 0, 1'b1);

    // slow qualification clock pattern
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin qs[i] = {7'd0, qck}; @(negedge clk); end
    r0 = -1;
    for (int i = 1; i <= 4; i++) if (r0 < 0 && qs[i][0] && !qs[i-1][0]) r0 = i;
    chk(r0 > 0, "R11 slow rising edge", r0, 1);
    if (r0 > 0)
      chk(qs[r0+1][0] && !qs[r0+2][0] && !qs[r0+3][0] && (r0 + 4 > 7 || qs[r0+4][0]),
          "R11 slow shape", int'({qs[r0+1][0], qs[r0+2][0], qs[r0+3][0]}), 3'b100);

    // fast qualification clock pattern
    fast = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 12; i++) begin qs[i] = {7'd0, qck}; ds[i] = d; @(negedge clk); end
    for (int i = 1; i < 12; i++) begin
      chk(qs[i][0] != qs[i-1][0], "R10 fast toggle", int'(qs[i][0]), int'(!qs[i-1][0]));
      if (qs[i-1][0]) chk(ds[i] == ds[i-1], "R10 nibble held over fall", int'(ds[i]), int'(ds[i-1]));
    end
    fast = 0;

    // release request
    hiz = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(out_en == 1'b0 && d == 5'd0 && qck == 1'b0 && fst == 1'b0, "R13 released outputs",
          int'({out_en, d, qck, fst}), 0);
    end
    hiz = 0;
    @(negedge clk);
    chk(out_en == 1'b1, "R13 enable restored", int'(out_en), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule